// File: doc/BRIEF.md
# Dispatch Stall and Skid-Buffer Controller

This block is the dispatch front end for one hardware thread. It sits between the rename stage and the issue and load/store queues. Each cycle it takes a packed group of renamed instructions and forwards up to an issue-width number of them downstream. Instructions that rename has already marked as squashed are dropped, but they still count as consumed. Whenever dispatch cannot proceed, the block parks the incoming group in a skid buffer and raises a one-cycle block request toward rename. Later it replays the parked instructions, oldest first, and sends a one-cycle unblock pulse only when the buffer is empty again.

A five-state machine drives the behaviour. RUN and IDLE both dispatch straight from rename: the thread is IDLE when the cycle carried no rename input and RUN otherwise. BLK means dispatch is stalled. UNBLK means the skid buffer is draining. SQUASH means a flush has happened. Each cycle the inputs are examined in a fixed priority order:
- a commit squash flushes everything, moving any state to SQUASH;
- a reorder-buffer-still-squashing flag drops the rename group, moving any state to SQUASH;
- any stall moves the thread to BLK;
- if none of these apply, BLK moves to UNBLK (or straight to RUN/IDLE when the buffer is empty) and SQUASH moves to RUN/IDLE.

The downstream queues are modelled only by their free-slot counts and a load/store stall flag. Upstream bookkeeping is kept in step through a per-cycle credit count: the total number of instructions consumed, and how many of them were memory operations.

Top module: `dispatch_ctl`

## Requirements
- R1: After reset, state_o reads RUN (encoding RUN=0, IDLE=1, BLK=2, UNBLK=3, SQUASH=4); block and unblock are low; nothing is dispatched.
- R2: In RUN or IDLE with no stall, up to IW instructions are taken from rename lane 0 upward and presented in order on dispatch lanes packed from lane 0. The next state is RUN if the cycle carried rename input and IDLE if it did not.
- R3: The skid buffer holds 3*DLY*RW+IW entries (14 by default), never overflows, and returns its contents in arrival order.
- R4: The inputs are prioritised in this order: commit squash, then the still-squashing flag, then stall, then the BLK and SQUASH transitions. A higher-priority condition masks every lower one in the same cycle.
- R5: A stall has four sources: the sticky commit stall, zero free issue-queue slots, zero free load/store slots, or the load/store stall flag. A stall pushes the whole rename group into the skid buffer, dispatches nothing and enters BLK. blk_o pulses only when the thread was not already in BLK or UNBLK.
- R6: From BLK with no stall, the thread dispatches from the skid buffer head and appends the rename group at the tail. unblk_o pulses, and the state returns to RUN/IDLE, only in the cycle the buffer becomes empty.
- R7: In RUN/IDLE, rename instructions left over beyond the IW examined slots go into the skid buffer, blk_o pulses, unblk_o is low, and the state becomes BLK.
- R8: A squashed instruction (squash bit set) uses a dispatch slot but is not sent downstream. It still adds 1 to cred_o, and also 1 to cred_mem_o if its memory bit is set.
- R9: A commit squash flushes the skid buffer and the rename group. All of them are credited (cred_o, cred_mem_o), nothing is dispatched, and unblk_o pulses if the thread was in BLK or UNBLK. The state becomes SQUASH; the next clean cycle dispatches from rename and leaves SQUASH.
- R10: While the still-squashing flag is set (and there is no commit squash), the rename group is dropped and credited, nothing is dispatched, no block or unblock is raised, and the state becomes SQUASH.
- R11: Dispatch stops at the first non-squashed instruction that finds no free issue-queue slot, or, for a memory instruction, no free load/store slot. The thread then blocks with unblk_o low, and the rest of the group is kept for replay.
- R12: The commit stall is sticky: it is set by a commit-block pulse and cleared by a commit-unblock pulse, and the clear wins when both pulses arrive together. An unblock pulse with no stall pending is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_cnt | input | RC_W | Number of valid rename lanes, packed from lane 0 |
| ren_tag | input | RW*8 | Instruction tag for each rename lane |
| ren_mem | input | RW | Memory (load/store) bit for each rename lane |
| ren_sq | input | RW | Already-squashed bit for each rename lane |
| commit_squash | input | 1 | Commit-stage squash for this thread |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| commit_blk | input | 1 | Commit stall set pulse |
| commit_unblk | input | 1 | Commit stall clear pulse |
| lsq_stall | input | 1 | Load/store queue stall |
| iq_free | input | FREE_W | Free issue-queue slots this cycle |
| lsq_free | input | FREE_W | Free load/store-queue slots this cycle |
| disp_valid | output | IW | Dispatch lane valid bits, packed from lane 0 |
| disp_tag | output | IW*8 | Tag on each dispatch lane |
| disp_mem | output | IW | Memory bit on each dispatch lane |
| blk_o | output | 1 | Block request to rename (pulse) |
| unblk_o | output | 1 | Unblock notice to rename (pulse) |
| cred_o | output | CR_W | Instructions consumed this cycle |
| cred_mem_o | output | CR_W | Memory instructions consumed this cycle |
| state_o | output | 3 | Current dispatch state |

## Verification
The assertions watch, on every cycle, for four things:
- skid-buffer overflow;
- an unblock pulse while the buffer still holds entries;
- lanes that are not packed, or any dispatch during a commit squash;
- a commit-unblock pulse with no stall pending.

They also check that every block request is followed by BLK and that every commit squash leads to SQUASH. Some behaviour can only be shown by the directed scenarios, because it needs a prepared history: oldest-first replay across several cycles, the exact credit totals when a squash flushes a partly filled buffer, where dispatch stops when a queue runs out of room mid-group, and the masking of a stall by a squash.

// File: rtl/dispatch_ctl_pkg.sv
package dispatch_ctl_pkg;
    localparam int TAG_W = 8;

    typedef struct packed {
        logic             squashed;
        logic             is_mem;
        logic [TAG_W-1:0] tag;
    } dinst_t;

    typedef enum logic [2:0] {
        DS_RUN    = 3'd0,
        DS_IDLE   = 3'd1,
        DS_BLK    = 3'd2,
        DS_UNBLK  = 3'd3,
        DS_SQUASH = 3'd4
    } dstate_e;
endpackage

// File: rtl/dispatch_skid.sv
module dispatch_skid
    import dispatch_ctl_pkg::*;
#(
    parameter int RW    = 4,
    parameter int IW    = 2,
    parameter int DEPTH = 14,
    parameter int CNT_W = 4,
    parameter int RC_W  = 3,
    parameter int IC_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [RC_W-1:0]  push_cnt,
    input  dinst_t           push_l [RW],
    input  logic [IC_W-1:0]  pop_cnt,
    output dinst_t           head_l [IW],
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] mem_count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    dinst_t          store [DEPTH];
    logic [PW-1:0]   head, tail;
    logic [CNT_W-1:0] push_mem, pop_mem;

    function automatic logic [PW-1:0] wrap(input int a);
        return PW'((a >= DEPTH) ? a - DEPTH : a);
    endfunction

    always_comb begin
        push_mem = '0;
        pop_mem  = '0;
        for (int j = 0; j < RW; j++)
            if (j < int'(push_cnt) && push_l[j].is_mem) push_mem = push_mem + 1'b1;
        for (int i = 0; i < IW; i++) begin
            head_l[i] = store[wrap(int'(head) + i)];
            if (i < int'(pop_cnt) && head_l[i].is_mem) pop_mem = pop_mem + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush)
            for (int j = 0; j < RW; j++)
                if (j < int'(push_cnt)) store[wrap(int'(tail) + j)] <= push_l[j];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head      <= '0;
            tail      <= '0;
            count     <= '0;
            mem_count <= '0;
        end else begin
            head      <= wrap(int'(head) + int'(pop_cnt));
            tail      <= wrap(int'(tail) + int'(push_cnt));
            count     <= count + CNT_W'(push_cnt) - CNT_W'(pop_cnt);
            mem_count <= mem_count + push_mem - pop_mem;
        end
    end
endmodule

// File: rtl/dispatch_pick.sv
module dispatch_pick
    import dispatch_ctl_pkg::*;
#(
    parameter int IW     = 2,
    parameter int FREE_W = 4,
    parameter int IC_W   = 2
) (
    input  dinst_t            src_l [IW],
    input  logic [IC_W-1:0]   src_cnt,
    input  logic [FREE_W-1:0] iq_free,
    input  logic [FREE_W-1:0] lsq_free,
    output logic [IW-1:0]     out_valid,
    output dinst_t            out_l [IW],
    output logic [IC_W-1:0]   n_cons,
    output logic [IC_W-1:0]   n_mem,
    output logic              stop
);
    int k, iq_u, lsq_u;

    always_comb begin
        out_valid = '0;
        n_cons    = '0;
        n_mem     = '0;
        stop      = 1'b0;
        k         = 0;
        iq_u      = 0;
        lsq_u     = 0;
        for (int i = 0; i < IW; i++) out_l[i] = '0;
        for (int i = 0; i < IW; i++) begin
            if (i < int'(src_cnt) && !stop) begin
                if (src_l[i].squashed) begin
                    n_cons = n_cons + 1'b1;
                    if (src_l[i].is_mem) n_mem = n_mem + 1'b1;
                end else if (iq_u >= int'(iq_free) ||
                             (src_l[i].is_mem && lsq_u >= int'(lsq_free))) begin
                    stop = 1'b1;
                end else begin
                    out_l[k]     = src_l[i];
                    out_valid[k] = 1'b1;
                    k            = k + 1;
                    iq_u         = iq_u + 1;
                    n_cons       = n_cons + 1'b1;
                    if (src_l[i].is_mem) begin
                        lsq_u = lsq_u + 1;
                        n_mem = n_mem + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/dispatch_ctl.sv
module dispatch_ctl
    import dispatch_ctl_pkg::*;
#(
    parameter  int RW     = 4,
    parameter  int IW     = 2,
    parameter  int DLY    = 1,
    parameter  int FREE_W = 4,
    localparam int DEPTH  = 3 * DLY * RW + IW,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int RC_W   = $clog2(RW + 1),
    localparam int IC_W   = $clog2(IW + 1),
    localparam int CR_W   = $clog2(DEPTH + RW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RC_W-1:0]   ren_cnt,
    input  logic [RW*TAG_W-1:0] ren_tag,
    input  logic [RW-1:0]     ren_mem,
    input  logic [RW-1:0]     ren_sq,
    input  logic              commit_squash,
    input  logic              rob_squashing,
    input  logic              commit_blk,
    input  logic              commit_unblk,
    input  logic              lsq_stall,
    input  logic [FREE_W-1:0] iq_free,
    input  logic [FREE_W-1:0] lsq_free,
    output logic [IW-1:0]     disp_valid,
    output logic [IW*TAG_W-1:0] disp_tag,
    output logic [IW-1:0]     disp_mem,
    output logic              blk_o,
    output logic              unblk_o,
    output logic [CR_W-1:0]   cred_o,
    output logic [CR_W-1:0]   cred_mem_o,
    output logic [2:0]        state_o
);
    dstate_e          st, nxt;
    logic             cs_q, cs_now, stall, src_skid, use_pick;
    dinst_t           ren_l  [RW];
    dinst_t           push_l [RW];
    dinst_t           head_l [IW];
    dinst_t           src_l  [IW];
    dinst_t           pick_l [IW];
    logic [IW-1:0]    pick_valid;
    logic [IC_W-1:0]  src_cnt, n_cons, n_mem, pop_cnt;
    logic             pick_stop, flush;
    logic [RC_W-1:0]  push_cnt, push_off;
    logic [CNT_W-1:0] skid_cnt, skid_mem;
    logic [RC_W-1:0]  ren_mem_cnt;

    for (genvar g = 0; g < RW; g++) begin : g_ren
        assign ren_l[g] = '{squashed: ren_sq[g], is_mem: ren_mem[g],
                            tag: ren_tag[g*TAG_W +: TAG_W]};
    end

    for (genvar g = 0; g < IW; g++) begin : g_out
        assign src_l[g] = src_skid ? head_l[g] : ren_l[g];
        assign disp_tag[g*TAG_W +: TAG_W] = pick_l[g].tag;
        assign disp_mem[g] = pick_l[g].is_mem;
    end

    // Sticky commit stall; a clear pulse wins over a set pulse.
    always_comb begin
        cs_now = cs_q;
        if (commit_blk)   cs_now = 1'b1;
        if (commit_unblk) cs_now = 1'b0;
    end

    assign stall    = cs_now || (iq_free == '0) || (lsq_free == '0) || lsq_stall;
    assign use_pick = !commit_squash && !rob_squashing && !stall;
    assign src_skid = (st == DS_UNBLK) || (st == DS_BLK && skid_cnt != '0);
    assign src_cnt  = src_skid ? ((int'(skid_cnt) > IW) ? IC_W'(IW) : IC_W'(skid_cnt))
                               : ((int'(ren_cnt)  > IW) ? IC_W'(IW) : IC_W'(ren_cnt));
    assign disp_valid = use_pick ? pick_valid : '0;
    assign state_o    = st;

    always_comb begin
        ren_mem_cnt = '0;
        for (int j = 0; j < RW; j++)
            if (j < int'(ren_cnt) && ren_mem[j]) ren_mem_cnt = ren_mem_cnt + 1'b1;
        for (int j = 0; j < RW; j++)
            push_l[j] = (int'(push_off) + j < RW) ? ren_l[int'(push_off) + j] : '0;
    end

    dispatch_pick #(.IW(IW), .FREE_W(FREE_W), .IC_W(IC_W)) pick_i (
        .src_l(src_l), .src_cnt(src_cnt), .iq_free(iq_free), .lsq_free(lsq_free),
        .out_valid(pick_valid), .out_l(pick_l), .n_cons(n_cons), .n_mem(n_mem),
        .stop(pick_stop)
    );

    dispatch_skid #(.RW(RW), .IW(IW), .DEPTH(DEPTH), .CNT_W(CNT_W),
                    .RC_W(RC_W), .IC_W(IC_W)) skid_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_cnt(push_cnt),
        .push_l(push_l), .pop_cnt(pop_cnt), .head_l(head_l),
        .count(skid_cnt), .mem_count(skid_mem)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= DS_RUN;
            cs_q <= 1'b0;
        end else begin
            st   <= nxt;
            cs_q <= cs_now;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt        = st;
        blk_o      = 1'b0;
        unblk_o    = 1'b0;
        flush      = 1'b0;
        push_cnt   = '0;
        push_off   = '0;
        pop_cnt    = '0;
        cred_o     = '0;
        cred_mem_o = '0;
        if (commit_squash) begin
            flush      = 1'b1;
            unblk_o    = (st == DS_BLK) || (st == DS_UNBLK);
            cred_o     = CR_W'(skid_cnt) + CR_W'(ren_cnt);
            cred_mem_o = CR_W'(skid_mem) + CR_W'(ren_mem_cnt);
            nxt        = DS_SQUASH;
        end else if (rob_squashing) begin
            cred_o     = CR_W'(ren_cnt);
            cred_mem_o = CR_W'(ren_mem_cnt);
            nxt        = DS_SQUASH;
        end else if (stall) begin
            blk_o    = (st != DS_BLK) && (st != DS_UNBLK);
            push_cnt = ren_cnt;
            nxt      = DS_BLK;
        end else begin
            cred_o     = CR_W'(n_cons);
            cred_mem_o = CR_W'(n_mem);
            if (st == DS_BLK && !src_skid) unblk_o = 1'b1;
            if (src_skid) begin
                pop_cnt  = n_cons;
                push_cnt = ren_cnt;
                if (pick_stop) begin
                    unblk_o = 1'b0;
                    nxt     = DS_BLK;
                end else if (int'(skid_cnt) - int'(n_cons) + int'(ren_cnt) == 0) begin
                    unblk_o = 1'b1;
                    nxt     = DS_RUN;
                end else begin
                    nxt = DS_UNBLK;
                end
            end else if (int'(n_cons) < int'(ren_cnt)) begin
                blk_o    = 1'b1;
                unblk_o  = 1'b0;
                push_off = RC_W'(n_cons);
                push_cnt = ren_cnt - RC_W'(n_cons);
                nxt      = DS_BLK;
            end else begin
                nxt = DS_RUN;
            end
        end
        unique case (nxt)
            DS_RUN, DS_IDLE: nxt = (ren_cnt == '0) ? DS_IDLE : DS_RUN;
            default:         nxt = nxt;
        endcase
    end
endmodule

// File: rtl/dispatch_ctl_chk.sv
module dispatch_ctl_chk #(
    parameter int IW    = 2,
    parameter int DEPTH = 14,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit_squash,
    input logic             commit_blk,
    input logic             commit_unblk,
    input logic             cs_q,
    input logic             blk_o,
    input logic             unblk_o,
    input logic [IW-1:0]    disp_valid,
    input logic [2:0]       state_o,
    input logic [CNT_W-1:0] skid_cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(skid_cnt) <= DEPTH);                                            // R3
    AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid & (disp_valid + 1'b1)) == '0);                           // R2
    AST_BLOCK_ENTERS_BLK: assert property (@(posedge clk) disable iff (!rst_n)
        blk_o |=> state_o == 3'd2);                                          // R5
    AST_BLOCK_NO_UNBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        blk_o |-> !unblk_o);                                                 // R7
    AST_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        unblk_o |=> skid_cnt == '0);                                         // R6
    AST_SQUASH_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        commit_squash |-> disp_valid == '0);                                 // R9
    AST_SQUASH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_squash |=> state_o == 3'd4);                                  // R4
    AST_STALL_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        commit_unblk |-> (cs_q || commit_blk));                              // R12
endmodule

bind dispatch_ctl dispatch_ctl_chk #(.IW(IW), .DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .commit_squash(commit_squash),
    .commit_blk(commit_blk), .commit_unblk(commit_unblk), .cs_q(cs_q),
    .blk_o(blk_o), .unblk_o(unblk_o), .disp_valid(disp_valid),
    .state_o(state_o), .skid_cnt(skid_cnt)
);

// File: tb/dispatch_ctl_tb_top.sv
`timescale 1ns/1ps
module dispatch_ctl_tb_top;
    localparam int RW = 4, IW = 2, DEPTH = 14, RC_W = 3, CR_W = 5, FREE_W = 4;
    localparam int S_RUN = 0, S_IDLE = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [RC_W-1:0]   ren_cnt = '0;
    logic [RW*8-1:0]   ren_tag = '0;
    logic [RW-1:0]     ren_mem = '0, ren_sq = '0;
    logic commit_squash = 0, rob_squashing = 0, commit_blk = 0, commit_unblk = 0, lsq_stall = 0;
    logic [FREE_W-1:0] iq_free = 4'd8, lsq_free = 4'd8;
    logic [IW-1:0]     disp_valid, disp_mem;
    logic [IW*8-1:0]   disp_tag;
    logic blk_o, unblk_o;
    logic [CR_W-1:0]   cred_o, cred_mem_o;
    logic [2:0]        state_o;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dispatch_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ren_cnt(ren_cnt), .ren_tag(ren_tag),
        .ren_mem(ren_mem), .ren_sq(ren_sq), .commit_squash(commit_squash),
        .rob_squashing(rob_squashing), .commit_blk(commit_blk),
        .commit_unblk(commit_unblk), .lsq_stall(lsq_stall), .iq_free(iq_free),
        .lsq_free(lsq_free), .disp_valid(disp_valid), .disp_tag(disp_tag),
        .disp_mem(disp_mem), .blk_o(blk_o), .unblk_o(unblk_o), .cred_o(cred_o),
        .cred_mem_o(cred_mem_o), .state_o(state_o)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int lane_tag(input int k);
        return int'(disp_tag[k*8 +: 8]);
    endfunction

    task automatic ren(input int cnt, input int base, input logic [3:0] mm, input logic [3:0] sm);
        ren_cnt = RC_W'(cnt);
        for (int i = 0; i < RW; i++) ren_tag[i*8 +: 8] = 8'(base + i);
        ren_mem = mm;
        ren_sq  = sm;
    endtask

    task automatic quiet();
        ren(0, 0, 4'b0, 4'b0);
        commit_squash = 0; rob_squashing = 0; commit_blk = 0; commit_unblk = 0;
        lsq_stall = 0; iq_free = 4'd8; lsq_free = 4'd8;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_out(input string req, input int valid, input int t0, input int t1,
                              input int blk, input int unblk, input int cred);
        check(req, "disp_valid", int'(disp_valid), valid);
        if (valid[0]) check(req, "lane0 tag", lane_tag(0), t0);
        if (valid[1]) check(req, "lane1 tag", lane_tag(1), t1);
        check(req, "blk", int'(blk_o), blk);
        check(req, "unblk", int'(unblk_o), unblk);
        check(req, "cred", int'(cred_o), cred);
    endtask

    task automatic t_reset();
        quiet(); settle();
        check("R1", "state", int'(state_o), S_RUN);
        check("R1", "blk", int'(blk_o), 0);
        check("R1", "unblk", int'(unblk_o), 0);
        check("R1", "disp_valid", int'(disp_valid), 0);
        tick();
    endtask

    task automatic t_run();
        quiet(); ren(2, 10, 4'b0010, 4'b0); settle();
        expect_out("R2", 3, 10, 11, 0, 0, 2);
        check("R2", "lane1 mem", int'(disp_mem[1]), 1);
        tick(); check("R2", "state run", int'(state_o), S_RUN);
        quiet(); settle(); expect_out("R2", 0, 0, 0, 0, 0, 0);
        tick(); check("R2", "state idle", int'(state_o), S_IDLE);
    endtask

    task automatic t_bandwidth();
        quiet(); ren(4, 20, 4'b0, 4'b0); settle();
        expect_out("R7", 3, 20, 21, 1, 0, 2);
        tick(); check("R7", "state", int'(state_o), S_BLK);
        quiet(); settle();
        expect_out("R6", 3, 22, 23, 0, 1, 2);
        tick(); check("R6", "state", int'(state_o), S_IDLE);
    endtask

    task automatic t_stall();
        quiet(); iq_free = 0; ren(3, 30, 4'b0, 4'b0); settle();
        expect_out("R5", 0, 0, 0, 1, 0, 0);
        tick(); check("R5", "state", int'(state_o), S_BLK);
        quiet(); iq_free = 0; ren(1, 33, 4'b0, 4'b0); settle();
        expect_out("R5", 0, 0, 0, 0, 0, 0);
        tick(); check("R5", "state held", int'(state_o), S_BLK);
        quiet(); ren(2, 34, 4'b0, 4'b0); settle();
        expect_out("R6", 3, 30, 31, 0, 0, 2);
        tick(); check("R6", "state", int'(state_o), S_UNB);
        quiet(); settle(); expect_out("R6", 3, 32, 33, 0, 0, 2);
        tick(); check("R6", "state", int'(state_o), S_UNB);
        quiet(); settle(); expect_out("R6", 3, 34, 35, 0, 1, 2);
        tick(); check("R6", "state", int'(state_o), S_IDLE);
        quiet(); lsq_stall = 1; ren(1, 36, 4'b0, 4'b0); settle();
        expect_out("R5", 0, 0, 0, 1, 0, 0);
        tick();
        quiet(); settle(); expect_out("R6", 1, 36, 0, 0, 1, 1);
        tick();
    endtask

    task automatic t_squashed();
        quiet(); ren(3, 40, 4'b0011, 4'b0001); settle();
        expect_out("R8", 1, 41, 0, 1, 0, 2);
        check("R8", "cred_mem", int'(cred_mem_o), 2);
        tick(); check("R8", "state", int'(state_o), S_BLK);
        quiet(); settle(); expect_out("R8", 1, 42, 0, 0, 1, 1);
        tick();
    endtask

    task automatic t_midfull();
        quiet(); iq_free = 1; ren(2, 50, 4'b0, 4'b0); settle();
        expect_out("R11", 1, 50, 0, 1, 0, 1);
        tick(); check("R11", "state", int'(state_o), S_BLK);
        quiet(); settle(); expect_out("R11", 1, 51, 0, 0, 1, 1);
        tick();
        quiet(); lsq_free = 1; ren(2, 52, 4'b0011, 4'b0); settle();
        expect_out("R11", 1, 52, 0, 1, 0, 1);
        check("R11", "cred_mem", int'(cred_mem_o), 1);
        tick();
        quiet(); settle(); expect_out("R11", 1, 53, 0, 0, 1, 1);
        tick();
    endtask

    task automatic t_squash();
        quiet(); iq_free = 0; ren(3, 60, 4'b0101, 4'b0); settle();
        expect_out("R5", 0, 0, 0, 1, 0, 0);
        tick();
        quiet(); iq_free = 0; commit_squash = 1; ren(2, 63, 4'b0001, 4'b0); settle();
        expect_out("R9", 0, 0, 0, 0, 1, 5);
        check("R9", "cred_mem", int'(cred_mem_o), 3);
        tick(); check("R4", "squash beats stall", int'(state_o), S_SQ);
        quiet(); ren(1, 65, 4'b0, 4'b0); settle();
        expect_out("R9", 1, 65, 0, 0, 0, 1);
        tick(); check("R9", "state", int'(state_o), S_RUN);
    endtask

    task automatic t_rob();
        quiet(); rob_squashing = 1; iq_free = 0; ren(2, 70, 4'b0010, 4'b0); settle();
        expect_out("R10", 0, 0, 0, 0, 0, 2);
        check("R10", "cred_mem", int'(cred_mem_o), 1);
        tick(); check("R4", "rob beats stall", int'(state_o), S_SQ);
        quiet(); settle(); expect_out("R10", 0, 0, 0, 0, 0, 0);
        tick(); check("R10", "state", int'(state_o), S_IDLE);
    endtask

    task automatic t_commit_stall();
        quiet(); commit_blk = 1; ren(1, 80, 4'b0, 4'b0); settle();
        expect_out("R12", 0, 0, 0, 1, 0, 0);
        tick(); check("R12", "state", int'(state_o), S_BLK);
        quiet(); settle(); expect_out("R12", 0, 0, 0, 0, 0, 0);
        tick(); check("R12", "sticky", int'(state_o), S_BLK);
        quiet(); commit_unblk = 1; settle();
        expect_out("R12", 1, 80, 0, 0, 1, 1);
        tick(); check("R12", "state", int'(state_o), S_IDLE);
    endtask

    task automatic t_capacity();
        for (int c = 0; c < 3; c++) begin
            quiet(); iq_free = 0; ren(4, 100 + 4*c, 4'b0, 4'b0); tick();
        end
        quiet(); iq_free = 0; ren(2, 112, 4'b0, 4'b0); tick();
        for (int k = 0; k < DEPTH/2; k++) begin
            quiet(); settle();
            expect_out("R3", 3, 100 + 2*k, 101 + 2*k, 0, (k == DEPTH/2 - 1) ? 1 : 0, 2);
            tick();
        end
        check("R3", "state", int'(state_o), S_IDLE);
    endtask

    initial begin
        quiet();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_run();
        t_bandwidth();
        t_stall();
        t_squashed();
        t_midfull();
        t_squash();
        t_rob();
        t_commit_stall();
        t_capacity();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule